// File: doc/BRIEF.md
# Kernel Stack Limit Checker

This block guards the kernel stack against overrun. Each time the processor touches memory through the stack pointer, it places a strobe on `chk_stb` together with the stack pointer value after adjustment, the current processor mode and the programmed limit. The checker compares the pointer against two thresholds above the limit. The result falls into one of three bands. In the safe band nothing happens. In the warning band a trap request is posted and the instruction carries on. In the fatal band the current cycle is aborted.

A fatal result, or a memory error while a trap or interrupt vector is being fetched, starts an emergency trap sequence. This sequence never uses the failed stack. It runs through a small single-transfer memory port at four fixed low addresses: it fetches the new status word, saves the old status word, saves the program counter, and fetches the new program counter. Two sticky flags record which band was reached. Software clears them by writing ones.

Top module: `stk_guard`

## Requirements
- R1: When `cpu_mode` is not 0 (0 is kernel), a strobe never raises `yel_trap` or `red_abort` and never sets a sticky flag.
- R2: In kernel mode, a stack pointer at or above limit+256 raises neither `yel_trap` nor `red_abort`, sets no flag and does not start the sequence.
- R3: In kernel mode, a stack pointer in [limit+224, limit+256) raises `yel_trap` in the strobe cycle and sets `err_yel` from the next cycle. `red_abort` and `busy` stay low.
- R4: In kernel mode, a stack pointer below limit+224 raises `red_abort` in the strobe cycle. From the next cycle `err_red` is set and `busy` is high.
- R5: Without `chk_stb`, no stack pointer value raises any output or flag.
- R6: The comparisons are unsigned. Limit+224 and limit+256 are formed at 17 bits, so a sum above 0xFFFF does not wrap. With limit 0xFF20 or higher, every kernel pointer is red.
- R7: `err_wr` with `err_wdata` bit 0 (warning) or bit 1 (fatal) set clears that flag at the next edge. A new event in the same cycle wins over the clear.
- R8: The sequence makes exactly four transfers, in this order: read 6, write 2 (the `cur_psw` captured at start), write 0 (the `cur_pc` captured at start), read 4. Each transfer holds its address until `mem_ack`. `busy` is high throughout.
- R9: After the read of address 4 is acknowledged, `busy` falls and `seq_done` pulses for one cycle. `new_psw` and `new_pc` then hold the words read from 6 and 4.
- R10: `vec_fault` is treated as a fatal result in any mode. It raises `red_abort`, sets `err_red` and starts the sequence.
- R11: A fatal event while `busy` is high sets `err_red` but does not restart or alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_mode | input | 2 | Current processor mode, 0 = kernel |
| chk_stb | input | 1 | A stack-pointer memory access happens this cycle |
| sp_val | input | 16 | Stack pointer after adjustment |
| lim_val | input | 16 | Programmed stack limit |
| vec_fault | input | 1 | Memory error during a vector fetch |
| cur_psw | input | 16 | Status word to save |
| cur_pc | input | 16 | Program counter to save |
| err_wr | input | 1 | Error flag clear strobe |
| err_wdata | input | 2 | Write-one-to-clear mask: bit 0 warning, bit 1 fatal |
| yel_trap | output | 1 | Warning trap request |
| red_abort | output | 1 | Abort the current cycle |
| err_yel | output | 1 | Sticky warning flag |
| err_red | output | 1 | Sticky fatal flag |
| busy | output | 1 | Emergency sequence running |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 16 | Transfer address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 16 | Read data |
| new_psw | output | 16 | Status word fetched by the sequence |
| new_pc | output | 16 | Program counter fetched by the sequence |
| seq_done | output | 1 | One-cycle pulse when the sequence ends |

## Verification
The bench sweeps the stack pointer across the whole 16-bit range, with extra points at limit+223, +224, +255 and +256, for limits near zero, mid-range and close to the top. A design with an off-by-one threshold misfiles those edge points. A design that forms the sums at 16 bits lets a high limit wrap into the safe band. Non-kernel modes and strobe-less cycles are driven with fatal pointer values, which exposes a missing mode or strobe gate. The emergency sequence is logged transfer by transfer and checked for order, direction and captured data. The bench then fires a second fatal event mid-sequence and a vector fault outside kernel mode, and a design that restarts or skips the sequence in those cases produces a wrong log or no completion pulse.

// File: rtl/stk_guard_pkg.sv
package stk_guard_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_RD_PSW = 3'd1,
        SQ_WR_PSW = 3'd2,
        SQ_WR_PC  = 3'd3,
        SQ_RD_PC  = 3'd4
    } seq_st_e;

    typedef struct packed {
        logic yel;
        logic red;
    } err_bits_t;

endpackage

// File: rtl/stk_zone_cmp.sv
module stk_zone_cmp #(
    parameter int W        = 16,
    parameter int YEL_OFS  = 224,
    parameter int SAFE_OFS = 256,
    parameter int KMODE    = 0
) (
    input  logic [1:0]   cpu_mode,
    input  logic         chk_stb,
    input  logic [W-1:0] sp_val,
    input  logic [W-1:0] lim_val,
    output logic         yel_hit,
    output logic         red_hit
);
    localparam int CW = W + 1;

    logic [CW-1:0] yel_base;
    logic [CW-1:0] safe_base;
    logic [CW-1:0] sp_ext;
    logic          armed;

    always_comb begin
        yel_base  = {1'b0, lim_val} + CW'(YEL_OFS);
        safe_base = {1'b0, lim_val} + CW'(SAFE_OFS);
        sp_ext    = {1'b0, sp_val};
        armed     = chk_stb && (cpu_mode == 2'(KMODE));
        red_hit   = armed && (sp_ext < yel_base);
        yel_hit   = armed && (sp_ext >= yel_base) && (sp_ext < safe_base);
    end

endmodule

// File: rtl/stk_red_seq.sv
module stk_red_seq
    import stk_guard_pkg::*;
#(
    parameter int W          = 16,
    parameter int A_PC_SAVE  = 0,
    parameter int A_PSW_SAVE = 2,
    parameter int A_NEW_PC   = 4,
    parameter int A_NEW_PSW  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] cur_psw,
    input  logic [W-1:0] cur_pc,
    input  logic         mem_ack,
    input  logic [W-1:0] mem_rdata,
    output logic         busy,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic [W-1:0] new_psw,
    output logic [W-1:0] new_pc,
    output logic         seq_done
);
    typedef struct packed {
        seq_st_e      st;
        logic [W-1:0] psw;
        logic [W-1:0] pc;
        logic [W-1:0] npsw;
        logic [W-1:0] npc;
        logic         done;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (r_q.st)
            SQ_IDLE: begin
                if (start) begin
                    r_d.st  = SQ_RD_PSW;
                    r_d.psw = cur_psw;
                    r_d.pc  = cur_pc;
                end
            end
            SQ_RD_PSW: begin
                mem_addr = W'(A_NEW_PSW);
                if (mem_ack) begin
                    r_d.npsw = mem_rdata;
                    r_d.st   = SQ_WR_PSW;
                end
            end
            SQ_WR_PSW: begin
                mem_addr  = W'(A_PSW_SAVE);
                mem_we    = 1'b1;
                mem_wdata = r_q.psw;
                if (mem_ack) r_d.st = SQ_WR_PC;
            end
            SQ_WR_PC: begin
                mem_addr  = W'(A_PC_SAVE);
                mem_we    = 1'b1;
                mem_wdata = r_q.pc;
                if (mem_ack) r_d.st = SQ_RD_PC;
            end
            SQ_RD_PC: begin
                mem_addr = W'(A_NEW_PC);
                if (mem_ack) begin
                    r_d.npc  = mem_rdata;
                    r_d.done = 1'b1;
                    r_d.st   = SQ_IDLE;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != SQ_IDLE);
    assign mem_req  = busy;
    assign new_psw  = r_q.npsw;
    assign new_pc   = r_q.npc;
    assign seq_done = r_q.done;

endmodule

// File: rtl/stk_guard.sv
module stk_guard
    import stk_guard_pkg::*;
#(
    parameter int W          = 16,
    parameter int YEL_OFS    = 224,
    parameter int SAFE_OFS   = 256,
    parameter int KMODE      = 0,
    parameter int A_PC_SAVE  = 0,
    parameter int A_PSW_SAVE = 2,
    parameter int A_NEW_PC   = 4,
    parameter int A_NEW_PSW  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   cpu_mode,
    input  logic         chk_stb,
    input  logic [W-1:0] sp_val,
    input  logic [W-1:0] lim_val,
    input  logic         vec_fault,
    input  logic [W-1:0] cur_psw,
    input  logic [W-1:0] cur_pc,
    input  logic         err_wr,
    input  logic [1:0]   err_wdata,
    output logic         yel_trap,
    output logic         red_abort,
    output logic         err_yel,
    output logic         err_red,
    output logic         busy,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic         mem_ack,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] new_psw,
    output logic [W-1:0] new_pc,
    output logic         seq_done
);
    logic      yel_hit, red_hit;
    err_bits_t err_d, err_q;

    stk_zone_cmp #(
        .W(W), .YEL_OFS(YEL_OFS), .SAFE_OFS(SAFE_OFS), .KMODE(KMODE)
    ) u_cmp (
        .cpu_mode (cpu_mode),
        .chk_stb  (chk_stb),
        .sp_val   (sp_val),
        .lim_val  (lim_val),
        .yel_hit  (yel_hit),
        .red_hit  (red_hit)
    );

    assign yel_trap  = yel_hit;
    assign red_abort = red_hit || vec_fault;

    // Sticky flags: an event this cycle outranks a clear.
    always_comb begin
        err_d = err_q;
        if (err_wr && err_wdata[0]) err_d.yel = 1'b0;
        if (err_wr && err_wdata[1]) err_d.red = 1'b0;
        if (yel_trap)  err_d.yel = 1'b1;
        if (red_abort) err_d.red = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err_yel = err_q.yel;
    assign err_red = err_q.red;

    stk_red_seq #(
        .W(W), .A_PC_SAVE(A_PC_SAVE), .A_PSW_SAVE(A_PSW_SAVE),
        .A_NEW_PC(A_NEW_PC), .A_NEW_PSW(A_NEW_PSW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (red_abort),
        .cur_psw   (cur_psw),
        .cur_pc    (cur_pc),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .new_psw   (new_psw),
        .new_pc    (new_pc),
        .seq_done  (seq_done)
    );

endmodule

// File: rtl/stk_guard_chk.sv
module stk_guard_chk #(
    parameter int W         = 16,
    parameter int KMODE     = 0,
    parameter int A_NEW_PSW = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   cpu_mode,
    input logic         vec_fault,
    input logic         err_wr,
    input logic [1:0]   err_wdata,
    input logic         yel_trap,
    input logic         red_abort,
    input logic         err_yel,
    input logic         err_red,
    input logic         busy,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic         mem_ack,
    input logic         seq_done
);
    // R1
    nonkernel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mode != 2'(KMODE) && !vec_fault) |-> (!yel_trap && !red_abort));

    // R3
    yel_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        yel_trap |=> err_yel);

    // R4
    red_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        red_abort |=> err_red);

    // R4
    red_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (red_abort && !busy) |=> (busy && mem_addr == W'(A_NEW_PSW) && !mem_we));

    // R7
    yel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wr && err_wdata[0] && !yel_trap) |=> !err_yel);

    // R7
    red_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wr && err_wdata[1] && !red_abort) |=> !err_red);

    // R8
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ack) |=> (busy && $stable(mem_addr) && $stable(mem_we)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!busy && $past(busy)));

endmodule

bind stk_guard stk_guard_chk #(.W(W), .KMODE(KMODE), .A_NEW_PSW(A_NEW_PSW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_mode  (cpu_mode),
    .vec_fault (vec_fault),
    .err_wr    (err_wr),
    .err_wdata (err_wdata),
    .yel_trap  (yel_trap),
    .red_abort (red_abort),
    .err_yel   (err_yel),
    .err_red   (err_red),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .seq_done  (seq_done)
);

// File: tb/tb_stk_guard.sv
`timescale 1ns/1ps
module tb_stk_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cpu_mode;
    logic        chk_stb;
    logic [15:0] sp_val, lim_val;
    logic        vec_fault;
    logic [15:0] cur_psw, cur_pc;
    logic        err_wr;
    logic [1:0]  err_wdata;
    logic        yel_trap, red_abort, err_yel, err_red, busy;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [15:0] mem_rdata;
    logic [15:0] new_psw, new_pc;
    logic        seq_done;

    int n_chk = 0, n_fail = 0;
    int done_cnt;
    int log_n = 0;
    logic [15:0] log_addr [8];
    logic        log_we   [8];
    logic [15:0] log_wd   [8];
    bit          finished = 0;

    always #2.5 clk = ~clk;

    stk_guard dut (
        .clk(clk), .rst_n(rst_n), .cpu_mode(cpu_mode), .chk_stb(chk_stb),
        .sp_val(sp_val), .lim_val(lim_val), .vec_fault(vec_fault),
        .cur_psw(cur_psw), .cur_pc(cur_pc), .err_wr(err_wr), .err_wdata(err_wdata),
        .yel_trap(yel_trap), .red_abort(red_abort), .err_yel(err_yel), .err_red(err_red),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .new_psw(new_psw), .new_pc(new_pc), .seq_done(seq_done)
    );

    function automatic logic [15:0] memval(input logic [15:0] a);
        return 16'hC000 ^ (a * 16'h0101);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Memory responder: one-cycle acknowledge, transfers logged in order.
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (log_n < 8) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                    log_wd[log_n]   = mem_wdata;
                end
                log_n++;
                mem_rdata = mem_we ? 16'h0 : memval(mem_addr);
                mem_ack = 1'b1;
            end
        end
    end

    task automatic wait_idle();
        int n = 0;
        done_cnt = 0;
        do begin
            @(negedge clk); #1;
            if (seq_done) done_cnt++;
            n++;
        end while (busy && n < 200);
    endtask

    task automatic clear_flags();
        @(negedge clk); err_wr = 1'b1; err_wdata = 2'b11;
        @(negedge clk); err_wr = 1'b0; err_wdata = 2'b00;
    endtask

    task automatic probe(input logic [1:0] md, input int sp, input int lim);
        int y, g;
        bit ek, er, ey;
        string tag;
        ek = (md == 2'd0);
        y = lim + 224;
        g = lim + 256;
        er = ek && (sp < y);
        ey = ek && (sp >= y) && (sp < g);
        tag = (g > 65535 && ek) ? "R6" : er ? "R4" : ey ? "R3" : ek ? "R2" : "R1";
        @(negedge clk);
        cpu_mode = md; sp_val = 16'(sp); lim_val = 16'(lim); chk_stb = 1'b1; #1;
        chk({yel_trap, red_abort} == {ey, er}, tag, "zone outputs",
            {30'd0, yel_trap, red_abort}, {30'd0, ey, er});
        @(negedge clk); chk_stb = 1'b0; #1;
        chk({err_yel, err_red, busy} == {ey, er, er}, tag, "flags/busy",
            {29'd0, err_yel, err_red, busy}, {29'd0, ey, er, er});
        if (busy) wait_idle();
        clear_flags();
    endtask

    function automatic int lim_at(input int i);
        case (i)
            0: return 0;
            1: return 16'h0100;
            2: return 16'h7F00;
            3: return 16'hFE00;
            4: return 16'hFF20;
            default: return 16'hFFC0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cpu_mode = 2'd0; chk_stb = 1'b0; sp_val = '0; lim_val = '0;
        vec_fault = 1'b0; cur_psw = 16'h00E0; cur_pc = 16'h0200;
        err_wr = 1'b0; err_wdata = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // R8 reset state
        chk({err_yel, err_red, busy, mem_req} == 4'b0, "R8", "reset state",
            {28'd0, err_yel, err_red, busy, mem_req}, 32'd0);

        // R2 R3 R4 R6: kernel sweep over the pointer range and band edges
        for (int li = 0; li < 6; li++) begin
            int lim = lim_at(li);
            for (int s = 0; s < 65536; s += 251) probe(2'd0, s, lim);
            for (int d = 223; d <= 256; d++) begin
                if ((d == 223 || d == 224 || d == 255 || d == 256) && lim + d < 65536)
                    probe(2'd0, lim + d, lim);
            end
            probe(2'd0, 65535, lim);
        end

        // R1: other modes at every band
        for (int m = 1; m < 4; m++) begin
            for (int s = 0; s < 65536; s += 4093) probe(2'(m), s, 16'h1000);
            probe(2'(m), 16'h1000 + 230, 16'h1000);
        end

        // R5: fatal pointer without strobe
        @(negedge clk); cpu_mode = 2'd0; sp_val = 16'h0000; lim_val = 16'h1000; chk_stb = 1'b0; #1;
        chk(!red_abort && !yel_trap, "R5", "no strobe outputs", {31'd0, red_abort}, 32'd0);
        @(negedge clk); #1;
        chk(!err_red && !busy, "R5", "no strobe flags", {30'd0, err_red, busy}, 32'd0);

        // R7: set wins over clear; per-bit clear
        @(negedge clk); sp_val = 16'h1000 + 16'd230; chk_stb = 1'b1; err_wr = 1'b1; err_wdata = 2'b01;
        @(negedge clk); chk_stb = 1'b0; err_wr = 1'b0; #1;
        chk(err_yel, "R7", "set beats clear", {31'd0, err_yel}, 32'd1);
        @(negedge clk); err_wr = 1'b1; err_wdata = 2'b10;
        @(negedge clk); err_wr = 1'b0; #1;
        chk(err_yel && !err_red, "R7", "other bit kept", {30'd0, err_yel, err_red}, 32'd2);
        @(negedge clk); err_wr = 1'b1; err_wdata = 2'b01;
        @(negedge clk); err_wr = 1'b0; #1;
        chk(!err_yel, "R7", "write one clears", {31'd0, err_yel}, 32'd0);

        // R8 R9: full sequence with captured values
        @(negedge clk); log_n = 0; cur_psw = 16'h1234; cur_pc = 16'hBEEF;
        sp_val = 16'h0010; lim_val = 16'h1000; chk_stb = 1'b1;
        @(negedge clk); chk_stb = 1'b0; cur_psw = 16'h5555; cur_pc = 16'h5555; #1;
        chk(busy && mem_addr == 16'd6 && !mem_we, "R8", "first transfer", {15'd0, busy, mem_addr}, {15'd0, 1'b1, 16'd6});
        wait_idle();
        chk(log_n == 4, "R8", "transfer count", log_n, 4);
        chk(log_addr[0] == 16'd6 && !log_we[0], "R8", "xfer0 read 6", {15'd0, log_we[0], log_addr[0]}, 32'd6);
        chk(log_addr[1] == 16'd2 && log_we[1] && log_wd[1] == 16'h1234, "R8", "xfer1 psw to 2",
            {log_wd[1], log_addr[1]}, {16'h1234, 16'd2});
        chk(log_addr[2] == 16'd0 && log_we[2] && log_wd[2] == 16'hBEEF, "R8", "xfer2 pc to 0",
            {log_wd[2], log_addr[2]}, {16'hBEEF, 16'd0});
        chk(log_addr[3] == 16'd4 && !log_we[3], "R8", "xfer3 read 4", {15'd0, log_we[3], log_addr[3]}, 32'd4);
        chk(done_cnt == 1 && !busy, "R9", "single done pulse", done_cnt, 1);
        chk(new_psw == memval(16'd6) && new_pc == memval(16'd4), "R9", "fetched words",
            {new_psw, new_pc}, {memval(16'd6), memval(16'd4)});
        clear_flags();

        // R11: second fatal event during the sequence
        @(negedge clk); log_n = 0; cur_psw = 16'h0F0F; cur_pc = 16'h2468; chk_stb = 1'b1;
        @(negedge clk); chk_stb = 1'b0;
        @(negedge clk); cur_pc = 16'h7777; chk_stb = 1'b1;
        @(negedge clk); chk_stb = 1'b0; #1;
        chk(err_red, "R11", "flag set while busy", {31'd0, err_red}, 32'd1);
        wait_idle();
        chk(log_n == 4 && log_wd[2] == 16'h2468, "R11", "sequence not restarted",
            {log_n[15:0], log_wd[2]}, {16'd4, 16'h2468});
        chk(done_cnt == 1, "R11", "one completion", done_cnt, 1);
        clear_flags();

        // R10: vector fault outside kernel mode
        @(negedge clk); log_n = 0; cpu_mode = 2'd3; vec_fault = 1'b1; #1;
        chk(red_abort && !yel_trap, "R10", "fault aborts", {30'd0, yel_trap, red_abort}, 32'd1);
        @(negedge clk); vec_fault = 1'b0; #1;
        chk(err_red && busy, "R10", "fault flag and busy", {30'd0, err_red, busy}, 32'd3);
        wait_idle();
        chk(log_n == 4 && done_cnt == 1, "R10", "fault sequence", {log_n[15:0], done_cnt[15:0]}, {16'd4, 16'd1});

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule